// File: doc/BRIEF.md
# Rectangle Copy Path Dispatcher and Chunker

This block takes a single rectangle copy request and turns it into a stream of per-chunk command descriptors for downstream copy engines. A request names a source and a destination surface. For each surface it gives the layout (linear or swizzled), the bytes per pixel, the base byte offset and the pitch. It also gives the destination surface dimensions, the source and destination origins, and the copy width and height. From these the block picks one of three copy paths. It then walks the rectangle in chunks that the chosen path can legally handle, and presents each chunk on a valid/ready output. Each chunk carries its position, its size and the source and destination byte offsets.

Three paths exist. The linear path moves runs of whole lines, at most `LIN_MAX` lines per chunk, and advances both offsets by pitch times line count after each run. The swizzle path cuts the rectangle into tiles of at most `TILE_MAX` by `TILE_MAX`. The tiles are walked row of tiles by row of tiles, left to right, and clipped at the right and bottom edges. The fallback path, meant for a per-pixel engine, gets a single descriptor covering the whole rectangle. A swizzle request whose destination dimensions are not powers of two is rejected with an error flag. An empty rectangle completes with no descriptors.

The control is a four-state machine. ST_IDLE accepts a request (transition "accept"). ST_CLASSIFY selects the path and loads the chunk cursor and offset accumulators. From there it goes either to ST_EMIT ("start") or, for an empty or rejected request, straight to ST_FINISH ("skip"). ST_EMIT presents descriptors and moves on a handshake ("step"). After the handshake of the last chunk it goes to ST_FINISH ("last"). ST_FINISH pulses `done` and returns to ST_IDLE ("retire").

Top module: `surf_copy_dispatch`

## Requirements
- R1: The linear path (code 0 on `cmd_path`) is selected when both layouts are linear (layout bit 0 = linear, 1 = swizzled), or when the destination width is at most 2, or when the destination height is at most 1.
- R2: Otherwise, the swizzle path (code 1) is selected when the source is linear, the destination is swizzled, the destination bytes per pixel is not 1, and the destination base is a multiple of `ALIGN_BYTES`.
- R3: Every other non-empty request selects the fallback path (code 2). It emits exactly one descriptor with origin (0,0), the full width and height, and linear start offsets for both surfaces.
- R4: The swizzle path emits tiles no larger than `TILE_MAX` in either dimension. They come row of tiles by row of tiles, left to right. Edge tiles are clipped to the remaining size, and the tiles cover the rectangle exactly once.
- R5: The linear path emits full-width chunks of at most `LIN_MAX` lines, top to bottom. After each chunk, both offsets grow by their pitch times that chunk's line count.
- R6: The first linear chunk has source offset src_base + src_y*src_pitch + src_x*src_bpp and destination offset dst_base + dst_y*dst_pitch + dst_x*dst_bpp.
- R7: For swizzle tiles, `cmd_point` is ((dst_y+ty) << COORD_W) | (dst_x+tx) and `cmd_size` is (th << COORD_W) | tw. `cmd_hw_size` packs th and tw each rounded up to even. The source offset is src_base + (src_y+ty)*src_pitch + (src_x+tx)*src_bpp, and the destination offset is dst_base.
- R8: A request that selects the swizzle path with a destination width or height that is not a power of two emits no descriptor, and `err` pulses together with `done`.
- R9: A request with zero width or zero height emits no descriptor and pulses `done` without `err`.
- R10: `req_ready` is high only while idle. `busy` is high from the cycle after acceptance through the `done` cycle, and `done` is a single-cycle pulse. A request held valid during a copy is not accepted until the block is idle again.
- R11: While `cmd_valid` is high and `cmd_ready` is low, the descriptor stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_src_layout | input | 1 | Source layout, 0 linear, 1 swizzled |
| req_dst_layout | input | 1 | Destination layout, 0 linear, 1 swizzled |
| req_src_bpp | input | BPP_W | Source bytes per pixel |
| req_dst_bpp | input | BPP_W | Destination bytes per pixel |
| req_src_base | input | OFF_W | Source base byte offset |
| req_dst_base | input | OFF_W | Destination base byte offset |
| req_src_pitch | input | PITCH_W | Source bytes per line |
| req_dst_pitch | input | PITCH_W | Destination bytes per line |
| req_dst_w | input | COORD_W | Destination surface width |
| req_dst_h | input | COORD_W | Destination surface height |
| req_src_x | input | COORD_W | Source origin x |
| req_src_y | input | COORD_W | Source origin y |
| req_dst_x | input | COORD_W | Destination origin x |
| req_dst_y | input | COORD_W | Destination origin y |
| req_w | input | COORD_W | Copy width in pixels |
| req_h | input | COORD_W | Copy height in lines |
| cmd_valid | output | 1 | Descriptor present |
| cmd_ready | input | 1 | Consumer takes the descriptor |
| cmd_path | output | 2 | Path code: 0 linear, 1 swizzle, 2 fallback |
| cmd_x | output | COORD_W | Chunk x relative to the rectangle |
| cmd_y | output | COORD_W | Chunk y relative to the rectangle |
| cmd_w | output | COORD_W | Chunk width |
| cmd_h | output | COORD_W | Chunk height |
| cmd_point | output | 2*COORD_W | Packed absolute destination point, y high |
| cmd_size | output | 2*COORD_W | Packed chunk size, height high |
| cmd_hw_size | output | 2*COORD_W | Packed size rounded up to even |
| cmd_src_off | output | OFF_W | Source byte offset of the chunk |
| cmd_dst_off | output | OFF_W | Destination byte offset of the chunk |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejection flag, pulses with done |

## Verification
Two things can coincide with the handshake of the final descriptor. One is backpressure, where a stall is released on exactly the last chunk. The other is a second request that has been held valid on the input for the whole copy. The bench keeps `req_valid` high from acceptance until it sees `done`, and stalls `cmd_ready` in a repeating pattern that lands on first, middle and last chunks across the sweep. Each cycle it judges that `req_ready` stays low while `busy` is high. It also checks that a stalled descriptor is unchanged one cycle later, and that the descriptor count and the exact-once coverage map come out right for every rectangle size just below, at and above each chunk limit.

// File: rtl/surf_copy_pkg.sv
package surf_copy_pkg;

    typedef enum logic [1:0] {
        PATH_LINEAR   = 2'd0,
        PATH_SWIZZLE  = 2'd1,
        PATH_FALLBACK = 2'd2
    } path_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CLASSIFY = 2'd1,
        ST_EMIT     = 2'd2,
        ST_FINISH   = 2'd3
    } state_e;

    localparam logic LAYOUT_LINEAR   = 1'b0;
    localparam logic LAYOUT_SWIZZLED = 1'b1;

endpackage

// File: rtl/surf_path_select.sv
module surf_path_select
    import surf_copy_pkg::*;
#(
    parameter int COORD_W     = 16,
    parameter int OFF_W       = 32,
    parameter int BPP_W       = 3,
    parameter int ALIGN_BYTES = 64
) (
    input  logic               src_layout,
    input  logic               dst_layout,
    input  logic [BPP_W-1:0]   dst_bpp,
    input  logic [OFF_W-1:0]   dst_base,
    input  logic [COORD_W-1:0] dst_w,
    input  logic [COORD_W-1:0] dst_h,
    input  logic [COORD_W-1:0] rect_w,
    input  logic [COORD_W-1:0] rect_h,
    output path_e              path,
    output logic               reject,
    output logic               empty
);
    localparam logic [OFF_W-1:0]   ALIGN_MASK = OFF_W'(ALIGN_BYTES - 1);
    localparam logic [COORD_W-1:0] ONE_C      = COORD_W'(1);
    localparam logic [COORD_W-1:0] TWO_C      = COORD_W'(2);
    localparam logic [BPP_W-1:0]   ONE_B      = BPP_W'(1);

    logic both_linear;
    logic degenerate;
    logic swz_ok;
    logic w_pow2;
    logic h_pow2;

    always_comb begin
        both_linear = (src_layout == LAYOUT_LINEAR) && (dst_layout == LAYOUT_LINEAR);
        degenerate  = (dst_w <= TWO_C) || (dst_h <= ONE_C);
        swz_ok      = (src_layout == LAYOUT_LINEAR) &&
                      (dst_layout == LAYOUT_SWIZZLED) &&
                      (dst_bpp != ONE_B) &&
                      ((dst_base & ALIGN_MASK) == '0);
        w_pow2      = (dst_w != '0) && ((dst_w & (dst_w - ONE_C)) == '0);
        h_pow2      = (dst_h != '0) && ((dst_h & (dst_h - ONE_C)) == '0);
        empty       = (rect_w == '0) || (rect_h == '0);

        if (both_linear || degenerate) begin
            path = PATH_LINEAR;
        end else if (swz_ok) begin
            path = PATH_SWIZZLE;
        end else begin
            path = PATH_FALLBACK;
        end

        reject = !empty && (path == PATH_SWIZZLE) && !(w_pow2 && h_pow2);
    end

endmodule

// File: rtl/surf_chunk_walker.sv
module surf_chunk_walker
    import surf_copy_pkg::*;
#(
    parameter int COORD_W  = 16,
    parameter int TILE_MAX = 1024,
    parameter int LIN_MAX  = 2047
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  path_e              path,
    input  logic [COORD_W-1:0] rect_w,
    input  logic [COORD_W-1:0] rect_h,
    output logic [COORD_W-1:0] cx,
    output logic [COORD_W-1:0] cy,
    output logic [COORD_W-1:0] cw,
    output logic [COORD_W-1:0] ch,
    output logic               last
);
    localparam logic [COORD_W-1:0] TILE_L = COORD_W'(TILE_MAX);
    localparam logic [COORD_W-1:0] LIN_L  = COORD_W'(LIN_MAX);

    logic [COORD_W-1:0] rw_q;
    logic [COORD_W-1:0] rh_q;
    logic [COORD_W-1:0] lim_w_q;
    logic [COORD_W-1:0] lim_h_q;
    logic [COORD_W-1:0] rem_w;
    logic [COORD_W-1:0] rem_h;
    logic [COORD_W:0]   x_end;
    logic [COORD_W:0]   y_end;
    logic               row_end;

    always_comb begin
        rem_w   = rw_q - cx;
        rem_h   = rh_q - cy;
        cw      = (rem_w > lim_w_q) ? lim_w_q : rem_w;
        ch      = (rem_h > lim_h_q) ? lim_h_q : rem_h;
        x_end   = {1'b0, cx} + {1'b0, cw};
        y_end   = {1'b0, cy} + {1'b0, ch};
        row_end = (x_end == {1'b0, rw_q});
        last    = row_end && (y_end == {1'b0, rh_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cx      <= '0;
            cy      <= '0;
            rw_q    <= '0;
            rh_q    <= '0;
            lim_w_q <= '0;
            lim_h_q <= '0;
        end else if (load) begin
            cx   <= '0;
            cy   <= '0;
            rw_q <= rect_w;
            rh_q <= rect_h;
            unique case (path)
                PATH_LINEAR: begin
                    lim_w_q <= rect_w;
                    lim_h_q <= LIN_L;
                end
                PATH_SWIZZLE: begin
                    lim_w_q <= TILE_L;
                    lim_h_q <= TILE_L;
                end
                default: begin
                    lim_w_q <= rect_w;
                    lim_h_q <= rect_h;
                end
            endcase
        end else if (step) begin
            if (row_end) begin
                cx <= '0;
                cy <= y_end[COORD_W-1:0];
            end else begin
                cx <= x_end[COORD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/surf_offset_gen.sv
module surf_offset_gen
    import surf_copy_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int OFF_W   = 32,
    parameter int PITCH_W = 16,
    parameter int BPP_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  path_e              path,
    input  logic [COORD_W-1:0] cx,
    input  logic [COORD_W-1:0] cy,
    input  logic [COORD_W-1:0] ch,
    input  logic [OFF_W-1:0]   src_base,
    input  logic [OFF_W-1:0]   dst_base,
    input  logic [PITCH_W-1:0] src_pitch,
    input  logic [PITCH_W-1:0] dst_pitch,
    input  logic [BPP_W-1:0]   src_bpp,
    input  logic [BPP_W-1:0]   dst_bpp,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output logic [OFF_W-1:0]   src_off,
    output logic [OFF_W-1:0]   dst_off
);
    logic [OFF_W-1:0] sp_w;
    logic [OFF_W-1:0] dp_w;
    logic [OFF_W-1:0] sb_w;
    logic [OFF_W-1:0] db_w;
    logic [OFF_W-1:0] src_start;
    logic [OFF_W-1:0] dst_start;
    logic [OFF_W-1:0] tile_src;
    logic [OFF_W-1:0] acc_src_q;
    logic [OFF_W-1:0] acc_dst_q;

    always_comb begin
        sp_w      = OFF_W'(src_pitch);
        dp_w      = OFF_W'(dst_pitch);
        sb_w      = OFF_W'(src_bpp);
        db_w      = OFF_W'(dst_bpp);
        src_start = src_base + OFF_W'(src_y) * sp_w + OFF_W'(src_x) * sb_w;
        dst_start = dst_base + OFF_W'(dst_y) * dp_w + OFF_W'(dst_x) * db_w;
        tile_src  = src_base
                  + (OFF_W'(src_y) + OFF_W'(cy)) * sp_w
                  + (OFF_W'(src_x) + OFF_W'(cx)) * sb_w;
        if (path == PATH_SWIZZLE) begin
            src_off = tile_src;
            dst_off = dst_base;
        end else begin
            src_off = acc_src_q;
            dst_off = acc_dst_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_src_q <= '0;
            acc_dst_q <= '0;
        end else if (load) begin
            acc_src_q <= src_start;
            acc_dst_q <= dst_start;
        end else if (step && (path == PATH_LINEAR)) begin
            acc_src_q <= acc_src_q + OFF_W'(ch) * sp_w;
            acc_dst_q <= acc_dst_q + OFF_W'(ch) * dp_w;
        end
    end

endmodule

// File: rtl/surf_copy_dispatch.sv
module surf_copy_dispatch
    import surf_copy_pkg::*;
#(
    parameter int COORD_W     = 16,
    parameter int OFF_W       = 32,
    parameter int PITCH_W     = 16,
    parameter int BPP_W       = 3,
    parameter int TILE_MAX    = 1024,
    parameter int LIN_MAX     = 2047,
    parameter int ALIGN_BYTES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_src_layout,
    input  logic                 req_dst_layout,
    input  logic [BPP_W-1:0]     req_src_bpp,
    input  logic [BPP_W-1:0]     req_dst_bpp,
    input  logic [OFF_W-1:0]     req_src_base,
    input  logic [OFF_W-1:0]     req_dst_base,
    input  logic [PITCH_W-1:0]   req_src_pitch,
    input  logic [PITCH_W-1:0]   req_dst_pitch,
    input  logic [COORD_W-1:0]   req_dst_w,
    input  logic [COORD_W-1:0]   req_dst_h,
    input  logic [COORD_W-1:0]   req_src_x,
    input  logic [COORD_W-1:0]   req_src_y,
    input  logic [COORD_W-1:0]   req_dst_x,
    input  logic [COORD_W-1:0]   req_dst_y,
    input  logic [COORD_W-1:0]   req_w,
    input  logic [COORD_W-1:0]   req_h,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [1:0]           cmd_path,
    output logic [COORD_W-1:0]   cmd_x,
    output logic [COORD_W-1:0]   cmd_y,
    output logic [COORD_W-1:0]   cmd_w,
    output logic [COORD_W-1:0]   cmd_h,
    output logic [2*COORD_W-1:0] cmd_point,
    output logic [2*COORD_W-1:0] cmd_size,
    output logic [2*COORD_W-1:0] cmd_hw_size,
    output logic [OFF_W-1:0]     cmd_src_off,
    output logic [OFF_W-1:0]     cmd_dst_off,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    state_e state_q;
    state_e state_d;

    // Registered request
    logic               q_src_layout;
    logic               q_dst_layout;
    logic [BPP_W-1:0]   q_src_bpp;
    logic [BPP_W-1:0]   q_dst_bpp;
    logic [OFF_W-1:0]   q_src_base;
    logic [OFF_W-1:0]   q_dst_base;
    logic [PITCH_W-1:0] q_src_pitch;
    logic [PITCH_W-1:0] q_dst_pitch;
    logic [COORD_W-1:0] q_dst_w;
    logic [COORD_W-1:0] q_dst_h;
    logic [COORD_W-1:0] q_src_x;
    logic [COORD_W-1:0] q_src_y;
    logic [COORD_W-1:0] q_dst_x;
    logic [COORD_W-1:0] q_dst_y;
    logic [COORD_W-1:0] q_w;
    logic [COORD_W-1:0] q_h;

    path_e path_q;
    logic  reject_q;

    path_e sel_path;
    logic  sel_reject;
    logic  sel_empty;

    logic               accept;
    logic               load;
    logic               step;
    logic [COORD_W-1:0] cx;
    logic [COORD_W-1:0] cy;
    logic [COORD_W-1:0] cw;
    logic [COORD_W-1:0] ch;
    logic               last;
    logic [OFF_W-1:0]   src_off;
    logic [OFF_W-1:0]   dst_off;
    logic [COORD_W-1:0] abs_x;
    logic [COORD_W-1:0] abs_y;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign load   = (state_q == ST_CLASSIFY);
    assign step   = (state_q == ST_EMIT) && cmd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_src_layout <= LAYOUT_LINEAR;
            q_dst_layout <= LAYOUT_LINEAR;
            q_src_bpp    <= '0;
            q_dst_bpp    <= '0;
            q_src_base   <= '0;
            q_dst_base   <= '0;
            q_src_pitch  <= '0;
            q_dst_pitch  <= '0;
            q_dst_w      <= '0;
            q_dst_h      <= '0;
            q_src_x      <= '0;
            q_src_y      <= '0;
            q_dst_x      <= '0;
            q_dst_y      <= '0;
            q_w          <= '0;
            q_h          <= '0;
        end else if (accept) begin
            q_src_layout <= req_src_layout;
            q_dst_layout <= req_dst_layout;
            q_src_bpp    <= req_src_bpp;
            q_dst_bpp    <= req_dst_bpp;
            q_src_base   <= req_src_base;
            q_dst_base   <= req_dst_base;
            q_src_pitch  <= req_src_pitch;
            q_dst_pitch  <= req_dst_pitch;
            q_dst_w      <= req_dst_w;
            q_dst_h      <= req_dst_h;
            q_src_x      <= req_src_x;
            q_src_y      <= req_src_y;
            q_dst_x      <= req_dst_x;
            q_dst_y      <= req_dst_y;
            q_w          <= req_w;
            q_h          <= req_h;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path_q   <= PATH_LINEAR;
            reject_q <= 1'b0;
        end else if (load) begin
            path_q   <= sel_path;
            reject_q <= sel_reject;
        end
    end

    surf_path_select #(
        .COORD_W    (COORD_W),
        .OFF_W      (OFF_W),
        .BPP_W      (BPP_W),
        .ALIGN_BYTES(ALIGN_BYTES)
    ) u_select (
        .src_layout(q_src_layout),
        .dst_layout(q_dst_layout),
        .dst_bpp   (q_dst_bpp),
        .dst_base  (q_dst_base),
        .dst_w     (q_dst_w),
        .dst_h     (q_dst_h),
        .rect_w    (q_w),
        .rect_h    (q_h),
        .path      (sel_path),
        .reject    (sel_reject),
        .empty     (sel_empty)
    );

    surf_chunk_walker #(
        .COORD_W (COORD_W),
        .TILE_MAX(TILE_MAX),
        .LIN_MAX (LIN_MAX)
    ) u_walker (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .path  (sel_path),
        .rect_w(q_w),
        .rect_h(q_h),
        .cx    (cx),
        .cy    (cy),
        .cw    (cw),
        .ch    (ch),
        .last  (last)
    );

    surf_offset_gen #(
        .COORD_W(COORD_W),
        .OFF_W  (OFF_W),
        .PITCH_W(PITCH_W),
        .BPP_W  (BPP_W)
    ) u_offsets (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .path     (path_q),
        .cx       (cx),
        .cy       (cy),
        .ch       (ch),
        .src_base (q_src_base),
        .dst_base (q_dst_base),
        .src_pitch(q_src_pitch),
        .dst_pitch(q_dst_pitch),
        .src_bpp  (q_src_bpp),
        .dst_bpp  (q_dst_bpp),
        .src_x    (q_src_x),
        .src_y    (q_src_y),
        .dst_x    (q_dst_x),
        .dst_y    (q_dst_y),
        .src_off  (src_off),
        .dst_off  (dst_off)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: accept, start/skip, step/last, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_CLASSIFY;
                end
            end
            ST_CLASSIFY: begin
                if (sel_empty || sel_reject) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (cmd_ready && last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        abs_x       = q_dst_x + cx;
        abs_y       = q_dst_y + cy;
        req_ready   = (state_q == ST_IDLE);
        busy        = (state_q != ST_IDLE);
        cmd_valid   = (state_q == ST_EMIT);
        done        = (state_q == ST_FINISH);
        err         = (state_q == ST_FINISH) && reject_q;
        cmd_path    = path_q;
        cmd_x       = cx;
        cmd_y       = cy;
        cmd_w       = cw;
        cmd_h       = ch;
        cmd_point   = {abs_y, abs_x};
        cmd_size    = {ch, cw};
        cmd_hw_size = {ch + COORD_W'(ch[0]), cw + COORD_W'(cw[0])};
        cmd_src_off = src_off;
        cmd_dst_off = dst_off;
    end

endmodule

// File: rtl/surf_copy_dispatch_chk.sv
module surf_copy_dispatch_chk #(
    parameter int COORD_W  = 16,
    parameter int OFF_W    = 32,
    parameter int TILE_MAX = 1024,
    parameter int LIN_MAX  = 2047
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [1:0]           cmd_path,
    input logic [COORD_W-1:0]   cmd_x,
    input logic [COORD_W-1:0]   cmd_y,
    input logic [COORD_W-1:0]   cmd_w,
    input logic [COORD_W-1:0]   cmd_h,
    input logic [2*COORD_W-1:0] cmd_hw_size,
    input logic [OFF_W-1:0]     cmd_src_off,
    input logic [OFF_W-1:0]     cmd_dst_off,
    input logic                 busy,
    input logic                 done,
    input logic                 err
);
    localparam logic [COORD_W-1:0] TILE_L = COORD_W'(TILE_MAX);
    localparam logic [COORD_W-1:0] LIN_L  = COORD_W'(LIN_MAX);

    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy && !done); // R10

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_path) &&
            $stable(cmd_x) && $stable(cmd_y) && $stable(cmd_w) && $stable(cmd_h) &&
            $stable(cmd_src_off) && $stable(cmd_dst_off)); // R11

    AST_TILE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_path == 2'd1) |-> (cmd_w <= TILE_L) && (cmd_h <= TILE_L)); // R4

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_path == 2'd0) |-> (cmd_h <= LIN_L) && (cmd_x == '0)); // R5

    AST_NO_EMPTY_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_w != '0) && (cmd_h != '0)); // R9

    AST_HW_SIZE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_path == 2'd1) |-> !cmd_hw_size[0] && !cmd_hw_size[COORD_W]); // R7

endmodule

bind surf_copy_dispatch surf_copy_dispatch_chk #(
    .COORD_W (COORD_W),
    .OFF_W   (OFF_W),
    .TILE_MAX(TILE_MAX),
    .LIN_MAX (LIN_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_path   (cmd_path),
    .cmd_x      (cmd_x),
    .cmd_y      (cmd_y),
    .cmd_w      (cmd_w),
    .cmd_h      (cmd_h),
    .cmd_hw_size(cmd_hw_size),
    .cmd_src_off(cmd_src_off),
    .cmd_dst_off(cmd_dst_off),
    .busy       (busy),
    .done       (done),
    .err        (err)
);

// File: tb/tb_surf_copy_dispatch.sv
module tb_surf_copy_dispatch;
    localparam int CW = 8;
    localparam int OW = 32;
    localparam int PW = 16;
    localparam int BW = 3;
    localparam int TM = 4;
    localparam int LM = 7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic req_valid, req_ready;
    logic req_src_layout, req_dst_layout;
    logic [BW-1:0] req_src_bpp, req_dst_bpp;
    logic [OW-1:0] req_src_base, req_dst_base;
    logic [PW-1:0] req_src_pitch, req_dst_pitch;
    logic [CW-1:0] req_dst_w, req_dst_h, req_src_x, req_src_y, req_dst_x, req_dst_y, req_w, req_h;
    logic cmd_valid, cmd_ready;
    logic [1:0] cmd_path;
    logic [CW-1:0] cmd_x, cmd_y, cmd_w, cmd_h;
    logic [2*CW-1:0] cmd_point, cmd_size, cmd_hw_size;
    logic [OW-1:0] cmd_src_off, cmd_dst_off;
    logic busy, done, err;

    surf_copy_dispatch #(
        .COORD_W(CW), .OFF_W(OW), .PITCH_W(PW), .BPP_W(BW),
        .TILE_MAX(TM), .LIN_MAX(LM), .ALIGN_BYTES(64)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src_layout(req_src_layout), .req_dst_layout(req_dst_layout),
        .req_src_bpp(req_src_bpp), .req_dst_bpp(req_dst_bpp),
        .req_src_base(req_src_base), .req_dst_base(req_dst_base),
        .req_src_pitch(req_src_pitch), .req_dst_pitch(req_dst_pitch),
        .req_dst_w(req_dst_w), .req_dst_h(req_dst_h),
        .req_src_x(req_src_x), .req_src_y(req_src_y),
        .req_dst_x(req_dst_x), .req_dst_y(req_dst_y),
        .req_w(req_w), .req_h(req_h),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_path(cmd_path),
        .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .cmd_point(cmd_point), .cmd_size(cmd_size), .cmd_hw_size(cmd_hw_size),
        .cmd_src_off(cmd_src_off), .cmd_dst_off(cmd_dst_off),
        .busy(busy), .done(done), .err(err)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // request configuration
    int c_sl, c_dl, c_sb, c_db, c_sbase, c_dbase, c_sp, c_dp;
    int c_dw, c_dh, c_sx, c_sy, c_dx, c_dy, c_w, c_h;

    // expected chunk list
    int n_exp;
    int e_x[64], e_y[64], e_w[64], e_h[64];
    longint e_so[64], e_do[64];
    int cov[16][16];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int ev(input int v);
        return v + (v % 2);
    endfunction

    task automatic add_exp(input int x, input int y, input int w, input int h,
                           input longint so, input longint d_o);
        e_x[n_exp] = x; e_y[n_exp] = y; e_w[n_exp] = w; e_h[n_exp] = h;
        e_so[n_exp] = so & 64'hFFFF_FFFF; e_do[n_exp] = d_o & 64'hFFFF_FFFF;
        n_exp++;
    endtask

    task automatic build(input int path, input bit exp_err);
        n_exp = 0;
        if (exp_err || c_w == 0 || c_h == 0) return;
        if (path == 0) begin
            for (int y = 0; y < c_h; y = y + mn(LM, c_h - y))
                add_exp(0, y, c_w, mn(LM, c_h - y),
                        c_sbase + (c_sy + y) * c_sp + c_sx * c_sb,
                        c_dbase + (c_dy + y) * c_dp + c_dx * c_db);
        end else if (path == 1) begin
            for (int y = 0; y < c_h; y = y + mn(TM, c_h - y))
                for (int x = 0; x < c_w; x = x + mn(TM, c_w - x))
                    add_exp(x, y, mn(TM, c_w - x), mn(TM, c_h - y),
                            c_sbase + (c_sy + y) * c_sp + (c_sx + x) * c_sb,
                            c_dbase);
        end else begin
            add_exp(0, 0, c_w, c_h,
                    c_sbase + c_sy * c_sp + c_sx * c_sb,
                    c_dbase + c_dy * c_dp + c_dx * c_db);
        end
    endtask

    task automatic run(input int path, input bit exp_err, input string sel_tag);
        int idx;
        int guard;
        bit got_done;
        bit proto_ok;
        bit stall_prev;
        bit cov_ok;
        longint h_so, h_do;
        int h_x, h_y, h_w, h_h, h_p;
        string gtag, otag, ntag;
        build(path, exp_err);
        gtag = (path == 0) ? "R5" : (path == 1) ? "R4" : "R3";
        ntag = exp_err ? "R8" : (c_w == 0 || c_h == 0) ? "R9" : gtag;
        for (int i = 0; i < 16; i++) for (int j = 0; j < 16; j++) cov[i][j] = 0;
        @(negedge clk);
        req_src_layout = c_sl[0]; req_dst_layout = c_dl[0];
        req_src_bpp = BW'(c_sb); req_dst_bpp = BW'(c_db);
        req_src_base = OW'(c_sbase); req_dst_base = OW'(c_dbase);
        req_src_pitch = PW'(c_sp); req_dst_pitch = PW'(c_dp);
        req_dst_w = CW'(c_dw); req_dst_h = CW'(c_dh);
        req_src_x = CW'(c_sx); req_src_y = CW'(c_sy);
        req_dst_x = CW'(c_dx); req_dst_y = CW'(c_dy);
        req_w = CW'(c_w); req_h = CW'(c_h);
        req_valid = 1'b1;
        idx = 0; guard = 0; got_done = 0; proto_ok = 1; stall_prev = 0;
        h_so = 0; h_do = 0; h_x = 0; h_y = 0; h_w = 0; h_h = 0; h_p = 0;
        while (!got_done && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (!busy || req_ready) proto_ok = 0;
            if (stall_prev) begin
                chk(cmd_valid && cmd_src_off == OW'(h_so) && cmd_dst_off == OW'(h_do) &&
                    int'(cmd_x) == h_x && int'(cmd_y) == h_y && int'(cmd_w) == h_w &&
                    int'(cmd_h) == h_h && int'(cmd_path) == h_p,
                    "R11", "stalled descriptor changed", cmd_src_off, h_so);
            end
            if (cmd_valid && cmd_ready) begin
                if (idx < n_exp) begin
                    otag = (path == 0) ? ((idx == 0) ? "R6" : "R5") : (path == 1) ? "R7" : "R3";
                    chk(int'(cmd_path) == path, sel_tag, "path", cmd_path, path);
                    chk(int'(cmd_x) == e_x[idx] && int'(cmd_y) == e_y[idx] &&
                        int'(cmd_w) == e_w[idx] && int'(cmd_h) == e_h[idx], gtag, "chunk xywh",
                        {cmd_x, cmd_y, cmd_w, cmd_h},
                        (e_x[idx] << 24) | (e_y[idx] << 16) | (e_w[idx] << 8) | e_h[idx]);
                    chk(longint'(cmd_src_off) == e_so[idx], otag, "src offset", cmd_src_off, e_so[idx]);
                    chk(longint'(cmd_dst_off) == e_do[idx], otag, "dst offset", cmd_dst_off, e_do[idx]);
                    if (path == 1) begin
                        chk(int'(cmd_point) == (((c_dy + e_y[idx]) << CW) | (c_dx + e_x[idx])),
                            "R7", "packed point", cmd_point,
                            ((c_dy + e_y[idx]) << CW) | (c_dx + e_x[idx]));
                        chk(int'(cmd_size) == ((e_h[idx] << CW) | e_w[idx]), "R7", "packed size",
                            cmd_size, (e_h[idx] << CW) | e_w[idx]);
                        chk(int'(cmd_hw_size) == ((ev(e_h[idx]) << CW) | ev(e_w[idx])), "R7",
                            "even size", cmd_hw_size, (ev(e_h[idx]) << CW) | ev(e_w[idx]));
                    end
                end
                for (int yy = 0; yy < int'(cmd_h); yy++)
                    for (int xx = 0; xx < int'(cmd_w); xx++)
                        if (int'(cmd_y) + yy < 16 && int'(cmd_x) + xx < 16)
                            cov[int'(cmd_y) + yy][int'(cmd_x) + xx]++;
                idx++;
            end
            stall_prev = cmd_valid && !cmd_ready;
            h_so = cmd_src_off; h_do = cmd_dst_off; h_p = cmd_path;
            h_x = cmd_x; h_y = cmd_y; h_w = cmd_w; h_h = cmd_h;
            if (done) begin
                got_done = 1;
                req_valid = 1'b0;
                chk(err == exp_err, exp_err ? "R8" : ntag, "err at done", err, exp_err);
            end
        end
        chk(got_done, "R10", "done seen", got_done, 1);
        chk(proto_ok, "R10", "req_ready low while busy", proto_ok, 1);
        chk(idx == n_exp, ntag, "descriptor count", idx, n_exp);
        if (n_exp > 0) begin
            cov_ok = 1;
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    if (cov[i][j] != ((i < c_h && j < c_w) ? 1 : 0)) cov_ok = 0;
            chk(cov_ok, gtag, "exact-once tiling", cov_ok, 1);
        end
        @(negedge clk);
        chk(!busy && req_ready && !done, "R10", "idle after done", {busy, req_ready, done}, 3'b010);
    endtask

    initial begin
        int rc;
        rc = 0;
        cmd_ready = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            rc++;
            cmd_ready = (rc % 3) != 2;
        end
    end

    initial begin
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog R10 act=%0d exp=%0d", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int ws[6];
        int hs_lin[7];
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_src_layout = 1'b0; req_dst_layout = 1'b0;
        req_src_bpp = '0; req_dst_bpp = '0; req_src_base = '0; req_dst_base = '0;
        req_src_pitch = '0; req_dst_pitch = '0; req_dst_w = '0; req_dst_h = '0;
        req_src_x = '0; req_src_y = '0; req_dst_x = '0; req_dst_y = '0;
        req_w = '0; req_h = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy && !cmd_valid && !done && !err, "R10", "reset state",
            {req_ready, busy, cmd_valid, done, err}, 5'b10000);

        // linear path: both linear, heights around the run limit
        hs_lin = '{1, 6, 7, 8, 14, 15, 16};
        c_sl = 0; c_dl = 0; c_sb = 2; c_db = 2; c_sbase = 100; c_dbase = 2000;
        c_sp = 40; c_dp = 64; c_dw = 16; c_dh = 16; c_sx = 1; c_sy = 2; c_dx = 3; c_dy = 1;
        for (int wi = 1; wi <= 3; wi = wi + 2)
            foreach (hs_lin[k]) begin
                c_w = wi; c_h = hs_lin[k];
                run(0, 0, "R1");
            end

        // linear path forced by narrow or flat destination (R1)
        c_sl = 0; c_dl = 1; c_db = 2; c_dbase = 64; c_dw = 2; c_dh = 16; c_w = 3; c_h = 9;
        run(0, 0, "R1");
        c_dw = 16; c_dh = 1; c_w = 5; c_h = 8;
        run(0, 0, "R1");

        // swizzle sweep around the tile limit (R2, R4, R7)
        ws = '{1, 3, 4, 5, 8, 9};
        c_sl = 0; c_dl = 1; c_sb = 4; c_db = 4; c_sbase = 300; c_dbase = 128;
        c_sp = 80; c_dp = 64; c_dw = 16; c_dh = 16; c_sx = 2; c_sy = 1; c_dx = 5; c_dy = 3;
        foreach (ws[a])
            foreach (ws[b]) begin
                c_w = ws[a]; c_h = ws[b];
                run(1, 0, "R2");
            end

        // fallback: 1-byte destination, misaligned base, swizzled source (R3)
        c_db = 1; c_w = 5; c_h = 3;
        run(2, 0, "R3");
        c_db = 4; c_dbase = 96;
        run(2, 0, "R3");
        c_dbase = 128; c_sl = 1; c_dl = 0; c_w = 9; c_h = 6;
        run(2, 0, "R3");

        // non power-of-two destination on the swizzle path (R8)
        c_sl = 0; c_dl = 1; c_dw = 12; c_dh = 16; c_w = 4; c_h = 4;
        run(1, 1, "R8");
        c_dw = 16; c_dh = 6;
        run(1, 1, "R8");

        // empty rectangles (R9), including one that would also be rejected
        c_dh = 16; c_w = 0; c_h = 5;
        run(1, 0, "R9");
        c_w = 5; c_h = 0;
        run(1, 0, "R9");
        c_dw = 12; c_w = 0; c_h = 0;
        run(1, 0, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule